// File: doc/BRIEF.md
# Scan-Ordered Panel Word Sequencer

This block walks a row-major, one-bit-per-pixel frame buffer and produces the stream of 16-bit words that a linear bulk transfer has to push into a tiled LED panel, one scanned row at a time. The panel is built from tiles 64 pixels wide and 32 pixels tall. Each tile is split into an upper and a lower half of 16 rows that share one row scan. Tiles are chained side by side into horizontal strips, and strips are stacked vertically as levels. Because each bus word feeds two stacked levels at once and the first-stage column latches of every tile are addressed in a fixed order, the pixel bytes have to be gathered in a nested order rather than in raster order.

The sequencer issues two byte read addresses per word to a frame-buffer port with a one-cycle synchronous read. It joins the two returned bytes into a word and offers that word on a ready/valid output. A flag marks the last word of every scanned row and a second flag marks the last word of the frame. After reset the stream starts at row 0 and repeats frame after frame for as long as the consumer keeps taking words.

The nesting runs from innermost to outermost as follows. The latch index k counts 0 to 15 inside a tile. The tile index counts across the strip. The level pair counts down the stack. The scan row counts 0 to 15.

Top module: `panel_order_gen`

## Requirements
- R1: Each output word joins two bytes that share the same pixel row inside their level and the same column byte. The byte from the even level 2p is in bits 7:0 and the byte from level 2p+1 is in bits 15:8.
- R2: Inside one tile, latch index k runs from 0 to 15. For k below 8 the byte is taken from in-level row r (the scan row), and for k of 8 or more it is taken from row r+16. In both cases the column byte is (k mod 8) + 8*tile.
- R3: After the 16 words of one tile, the next tile of the same strip follows, in tile order 0 to NUM_TILES-1.
- R4: After the last tile of a level pair, the next pair follows, in pair order 0 to NUM_LEVELS/2-1.
- R5: After the last word of a scanned row, the next row follows. Rows run 0 to 15, and row 15 is followed by row 0 of a new frame.
- R6: out_eor is high only with the last word of a scanned row (last latch, last tile, last pair). out_eof is high only with the last word of row 15.
- R7: While rst is high, out_valid is low. At the first rising clock edge with rst low, out_valid rises and the word offered is row 0, pair 0, tile 0, k 0.
- R8: While out_valid is high and out_ready is low, the word and both flags hold. No word is skipped or repeated across a stall.
- R9: The byte address of a pixel byte is (level*32 + in-level row)*ROW_BYTES + column byte, with ROW_BYTES = 8*NUM_TILES. The frame-buffer data arrives one clock after its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_valid | output | 1 | A word is offered |
| out_data | output | 16 | Packed word, even level in bits 7:0 |
| out_eor | output | 1 | Last word of a scanned row |
| out_eof | output | 1 | Last word of the frame |
| rd_addr_lo | output | FB_AW | Byte address for the even level |
| rd_addr_hi | output | FB_AW | Byte address for the odd level |
| rd_data_lo | input | 8 | Byte read from rd_addr_lo, one clock later |
| rd_data_hi | input | 8 | Byte read from rd_addr_hi, one clock later |

## Verification
The bench builds the block with four levels and two tiles. That gives two level pairs and two tiles per strip, so every counter in the nest carries into the next one, and both the pair and tile terms of the address can be told apart from the latch term. Each frame-buffer byte holds a hash of its own address, so a word taken from the wrong row, half, tile or level shows up as a data mismatch. The consumer's ready is throttled in a fixed pattern and one long stall is added, so the lookahead addressing is exercised across a stall. A mid-stream reset checks that the sequence restarts at word zero.

// File: rtl/pog_pkg.sv
package pog_pkg;

    // Fixed panel geometry
    localparam int SCAN_ROWS      = 16;  // rows sharing one scan line
    localparam int LATCHES        = 16;  // first-stage column latches per tile
    localparam int HALF_LATCH     = 8;   // latches per tile half
    localparam int TILE_ROWS      = 32;  // pixel rows per level
    localparam int TILE_COL_BYTES = 8;   // 64 pixels wide, 1 bit each
    localparam int CTR_W          = 8;   // width of each nest counter

    // Nest positions, innermost first
    localparam int NEST_DEPTH = 4;
    localparam int NEST_LATCH = 0;
    localparam int NEST_TILE  = 1;
    localparam int NEST_PAIR  = 2;
    localparam int NEST_ROW   = 3;

    typedef struct packed {
        logic [CTR_W-1:0] row;
        logic [CTR_W-1:0] pair;
        logic [CTR_W-1:0] tile;
        logic [CTR_W-1:0] latch;
    } pos_t;

    // In-level pixel row selected by a latch index at a given scan row
    function automatic logic [31:0] level_row(pos_t p);
        logic [31:0] r;
        r = 32'(p.row);
        if (32'(p.latch) >= HALF_LATCH) r = r + 32'(TILE_ROWS / 2);
        return r;
    endfunction

    // Column byte inside the strip
    function automatic logic [31:0] strip_col(pos_t p);
        return 32'(p.latch) % HALF_LATCH + 32'(p.tile) * TILE_COL_BYTES;
    endfunction

endpackage

// File: rtl/pog_wrap_ctr.sv
module pog_wrap_ctr
    import pog_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [CTR_W-1:0] q_o,
    output logic [CTR_W-1:0] q_nxt_o,
    output logic             last_o
);

    assign last_o = (q_o == CTR_W'(LIMIT - 1));

    always_comb begin
        if (rst)
            q_nxt_o = '0;
        else if (inc_i)
            q_nxt_o = last_o ? '0 : q_o + CTR_W'(1);
        else
            q_nxt_o = q_o;
    end

    always_ff @(posedge clk) begin
        q_o <= q_nxt_o;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc_i && last_o) |=> (q_o == '0));  // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !last_o) |=> (q_o == $past(q_o) + CTR_W'(1)));  // R4

endmodule

// File: rtl/pog_addr_map.sv
module pog_addr_map
    import pog_pkg::*;
#(
    parameter int NUM_TILES = 2,
    parameter int AW        = 11
) (
    input  pos_t          pos_i,
    output logic [AW-1:0] addr_lo_o,
    output logic [AW-1:0] addr_hi_o
);

    localparam int ROW_BYTES   = TILE_COL_BYTES * NUM_TILES;
    localparam int LEVEL_BYTES = TILE_ROWS * ROW_BYTES;

    logic [31:0] fb_row;
    logic [31:0] lo_full;
    logic [31:0] hi_full;

    always_comb begin
        // even level of the pair is 2*pair
        fb_row  = 32'(pos_i.pair) * (2 * TILE_ROWS) + level_row(pos_i);
        lo_full = fb_row * ROW_BYTES + strip_col(pos_i);
        hi_full = lo_full + 32'(LEVEL_BYTES);
    end

    assign addr_lo_o = AW'(lo_full);
    assign addr_hi_o = AW'(hi_full);

endmodule

// File: rtl/panel_order_gen.sv
module panel_order_gen
    import pog_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int NUM_TILES  = 2,
    parameter int FB_AW      = $clog2(NUM_LEVELS * TILE_ROWS * TILE_COL_BYTES * NUM_TILES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [15:0]      out_data,
    output logic             out_eor,
    output logic             out_eof,
    output logic [FB_AW-1:0] rd_addr_lo,
    output logic [FB_AW-1:0] rd_addr_hi,
    input  logic [7:0]       rd_data_lo,
    input  logic [7:0]       rd_data_hi
);

    localparam int NUM_PAIRS = NUM_LEVELS / 2;
    localparam int NEST_LIMIT [NEST_DEPTH] = '{LATCHES, NUM_TILES, NUM_PAIRS, SCAN_ROWS};

    logic                  fire;
    logic [NEST_DEPTH-1:0] inc;
    logic [NEST_DEPTH-1:0] last;
    logic [CTR_W-1:0]      cur [NEST_DEPTH];
    logic [CTR_W-1:0]      nxt [NEST_DEPTH];
    pos_t                  cur_pos;
    pos_t                  nxt_pos;

    assign fire   = out_valid && out_ready;
    assign inc[0] = fire;

    // Nested wrap counters: latch, tile, pair, row
    generate
        for (genvar g = 0; g < NEST_DEPTH; g++) begin : g_nest
            pog_wrap_ctr #(.LIMIT(NEST_LIMIT[g])) u_ctr (
                .clk     (clk),
                .rst     (rst),
                .inc_i   (inc[g]),
                .q_o     (cur[g]),
                .q_nxt_o (nxt[g]),
                .last_o  (last[g])
            );
            if (g < NEST_DEPTH - 1) begin : g_carry
                assign inc[g+1] = inc[g] && last[g];
            end
        end
    endgenerate

    assign cur_pos = '{row: cur[NEST_ROW], pair: cur[NEST_PAIR],
                       tile: cur[NEST_TILE], latch: cur[NEST_LATCH]};
    assign nxt_pos = '{row: nxt[NEST_ROW], pair: nxt[NEST_PAIR],
                       tile: nxt[NEST_TILE], latch: nxt[NEST_LATCH]};

    // Address from the next position so data lines up with the current one
    pog_addr_map #(.NUM_TILES(NUM_TILES), .AW(FB_AW)) u_map (
        .pos_i     (nxt_pos),
        .addr_lo_o (rd_addr_lo),
        .addr_hi_o (rd_addr_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= 1'b1;
    end

    assign out_data = {rd_data_hi, rd_data_lo};
    assign out_eor  = last[NEST_LATCH] && last[NEST_TILE] && last[NEST_PAIR];
    assign out_eof  = out_eor && last[NEST_ROW];

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(cur_pos));  // R8

    AST_VALID_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);  // R7

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (fire && out_eor && !out_eof) |=> (cur_pos.row == $past(cur_pos.row) + CTR_W'(1)));  // R5

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (fire && out_eof) |=> (cur_pos == '0));  // R5

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
        (fire && !out_eor) |=> $stable(cur_pos.row));  // R6

endmodule

// File: tb/test_panel_order_gen.sv
module test_panel_order_gen;

    localparam int LEVELS    = 4;
    localparam int TILES     = 2;
    localparam int RB        = 8 * TILES;          // bytes per pixel row
    localparam int LVB       = 32 * RB;            // bytes per level
    localparam int FB_BYTES  = LEVELS * LVB;
    localparam int AW        = $clog2(FB_BYTES);
    localparam int ROW_WORDS = 16 * TILES * (LEVELS / 2);
    localparam int FRAME_W   = 16 * ROW_WORDS;

    // Spot vectors: {word number, expected even-level byte address, eor, eof}
    localparam int NSPOT = 9;
    localparam logic [25:0] SPOT [NSPOT] = '{
        {12'd0,    12'd0,    1'b0, 1'b0},
        {12'd9,    12'd257,  1'b0, 1'b0},
        {12'd23,   12'd15,   1'b0, 1'b0},
        {12'd40,   12'd1280, 1'b0, 1'b0},
        {12'd47,   12'd1287, 1'b0, 1'b0},
        {12'd63,   12'd1295, 1'b1, 1'b0},
        {12'd64,   12'd16,   1'b0, 1'b0},
        {12'd1023, 12'd1535, 1'b1, 1'b1},
        {12'd1024, 12'd0,    1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [15:0]   out_data;
    logic          out_eor;
    logic          out_eof;
    logic [AW-1:0] rd_addr_lo;
    logic [AW-1:0] rd_addr_hi;
    logic [7:0]    rd_data_lo;
    logic [7:0]    rd_data_hi;
    logic [7:0]    fb [FB_BYTES];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    panel_order_gen #(.NUM_LEVELS(LEVELS), .NUM_TILES(TILES)) i_panel_order_gen (
        .clk        (clk),
        .rst        (rst),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_eor    (out_eor),
        .out_eof    (out_eof),
        .rd_addr_lo (rd_addr_lo),
        .rd_addr_hi (rd_addr_hi),
        .rd_data_lo (rd_data_lo),
        .rd_data_hi (rd_data_hi)
    );

    // Frame-buffer model: one-clock synchronous read (R9)
    always_ff @(posedge clk) begin
        rd_data_lo <= fb[rd_addr_lo];
        rd_data_hi <= fb[rd_addr_hi];
    end

    function automatic logic [7:0] hash(int a);
        return 8'((a * 37) ^ (a >> 3) ^ (a >> 8));
    endfunction

    // Reference ordering, derived from the requirements
    function automatic int ref_lo(int n);
        int w, k, j, p, r, row;
        w   = n % FRAME_W;
        k   = w % 16;                          // R2 latch
        j   = (w / 16) % TILES;                // R3 tile
        p   = (w / (16 * TILES)) % (LEVELS / 2); // R4 pair
        r   = w / ROW_WORDS;                   // R5 scan row
        row = r + ((k >= 8) ? 16 : 0);
        return ((2 * p) * 32 + row) * RB + (k % 8) + 8 * j;
    endfunction

    function automatic logic [15:0] word_at(int lo);
        return {hash(lo + LVB), hash(lo)};     // R1 odd level high
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // Check a word about to be consumed as stream word n
    task automatic check_word(int n);
        int lo;
        lo = ref_lo(n);
        chk(out_data == word_at(lo), "R1 R2 R3 R4 R9 data", out_data, word_at(lo));
        chk(out_eor == (((n % ROW_WORDS) == ROW_WORDS - 1)), "R6 eor", out_eor,
            ((n % ROW_WORDS) == ROW_WORDS - 1));
        chk(out_eof == (((n % FRAME_W) == FRAME_W - 1)), "R5 R6 eof", out_eof,
            ((n % FRAME_W) == FRAME_W - 1));
        for (int t = 0; t < NSPOT; t++) begin
            if (int'(SPOT[t][25:14]) == n) begin
                chk(out_data == word_at(int'(SPOT[t][13:2])), "R2 R3 R4 spot data",
                    out_data, word_at(int'(SPOT[t][13:2])));
                chk(out_eor == SPOT[t][1], "R6 spot eor", out_eor, SPOT[t][1]);
                chk(out_eof == SPOT[t][0], "R5 spot eof", out_eof, SPOT[t][0]);
            end
        end
    endtask

    // Run until 'count' words have been consumed, throttled ready
    task automatic stream(int count, int stall_at);
        int n;
        int k;
        logic [15:0] held;
        logic held_eor;
        logic held_eof;
        n = 0;
        k = 0;
        while (n < count) begin
            @(negedge clk);
            k++;
            if (n == stall_at && out_valid) begin
                out_ready = 1'b0;
                #1;
                held     = out_data;
                held_eor = out_eor;
                held_eof = out_eof;
                for (int s = 0; s < 6; s++) begin
                    @(negedge clk);
                    #1;
                    chk(out_valid == 1'b1, "R8 valid in stall", out_valid, 1);
                    chk(out_data == held, "R8 data held", out_data, held);
                    chk({out_eor, out_eof} == {held_eor, held_eof}, "R8 flags held",
                        {out_eor, out_eof}, {held_eor, held_eof});
                end
                stall_at = -1;
                continue;
            end
            out_ready = ((k % 5) != 3);
            #1;
            if (out_valid && out_ready) begin
                check_word(n);
                n++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        for (int a = 0; a < FB_BYTES; a++) fb[a] = hash(a);
        rst = 1'b1;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R7 valid low in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b1, "R7 valid after release", out_valid, 1);
        chk(out_data == word_at(0), "R7 first word", out_data, word_at(0));
        out_ready = 1'b0;

        // Two full frames plus a little, one long stall mid-row
        stream(2 * FRAME_W + 40, 300);

        // Mid-stream reset restarts the order
        @(negedge clk);
        rst = 1'b1;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R7 valid low in second reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b1, "R7 valid after second release", out_valid, 1);
        chk(out_data == word_at(0), "R7 restart word", out_data, word_at(0));
        out_ready = 1'b0;
        stream(ROW_WORDS + 10, 63);

        summary();
    end

endmodule